// File: doc/BRIEF.md
# Load/Store Issue Interlock with Shared Data Port

This block is the issue-control logic of a single-issue core that retires one instruction per clock. Data loads and stores leave the core through one external memory port, and each access occupies that port for several cycles. Every cycle the decoder presents one instruction: its class, the register it writes and the two registers it reads. The block decides whether that instruction issues or holds the core with `stall`. When a load or store issues, the block starts the port transaction. It watches the port's completion pulse and reports the register that a finished load writes back.

Loads and stores do not block later instructions on their own. Only two things cause a stall. The first is a real dependency on a load whose data has not yet returned. The second is a second memory access while the single port is still occupied. Code that places independent work between a load and its consumer therefore hides the memory latency. Instruction fetch uses its own memory and plays no part here. A one-bit-per-register scoreboard records which register a pending load will fill.

Class encoding on `instr_op`: 2'b00 compute, 2'b01 load, 2'b10 store, 2'b11 reserved (handled like compute). A compute reads `instr_src_a` and `instr_src_b` and writes `instr_dst`. A load reads `instr_src_a` (address) and writes `instr_dst`. A store reads `instr_src_a` (data) and `instr_src_b` (address) and writes nothing.

Top module: `ldst_issue_ctrl`

## Requirements
- R1: When a load or store issues, `mem_start` is high in that same cycle. `mem_write` is 1 for a store and 0 for a load, and `mem_tag` carries `instr_dst`. When `mem_start` is low, `mem_write` and `mem_tag` are 0.
- R2: The port is busy from the cycle after `mem_start` through the cycle in which `mem_done` is high. A load or store presented while the port is busy stalls, and it issues in the cycle after `mem_done`.
- R3: A compute instruction whose `instr_src_a` or `instr_src_b` names the destination of a pending load stalls. It issues in the cycle after that load's `mem_done`.
- R4: A compute instruction that neither reads nor writes a pending load's destination issues without stall while the load is in flight.
- R5: A store never leaves anything for a later compute to wait on. Compute instructions following an issued store issue one per clock.
- R6: A store whose data or address register is the destination of a pending load stalls until the cycle after that load completes.
- R7: A compute instruction whose `instr_dst` is the destination of a pending load stalls until the cycle after that load completes.
- R8: In the cycle `mem_done` ends a load, `wb_valid` is 1 and `wb_reg` names the load's destination. When `mem_done` ends a store, `wb_valid` stays 0.
- R9: When `instr_valid` is 0, `stall` and `mem_start` are 0.
- R10: Synchronous reset clears the scoreboard and the port-busy state and drops `stall`. In the first cycle after reset, a load issues at once.
- R11: With a five-cycle port, the five instructions load, three dependent computes and store take 13 cycles, counted from the load's issue through the store's `mem_done`.
- R12: With the same port, two iterations of the reordered form take 20 cycles from the first issue through the last `mem_done`. In that form each load is followed by the computes and the store that use the previous load's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_op | input | 2 | Instruction class (00 compute, 01 load, 10 store, 11 reserved) |
| instr_dst | input | REG_W (4) | Destination register |
| instr_src_a | input | REG_W (4) | First source register |
| instr_src_b | input | REG_W (4) | Second source register |
| stall | output | 1 | Presented instruction does not issue this cycle |
| mem_start | output | 1 | Start of a data port transaction |
| mem_write | output | 1 | Transaction is a store |
| mem_tag | output | REG_W (4) | Destination register of the started transaction |
| mem_done | input | 1 | Port transaction completes this cycle |
| wb_valid | output | 1 | A load's data is written back this cycle |
| wb_reg | output | REG_W (4) | Register written back |

## Verification
A cycle-accurate model in the bench, with a five-cycle memory, is compared with every output on every clock. Directed streams cover three cases. The first is the dependent sequence, which shows whether a compute waits on a load's result (R3, R11). The second is the reordered sequence, which shows whether independent work overlaps the load and whether port contention alone paces the loop (R4, R12). The third is a short burst after reset with idle gaps, which tests R9 and R10. A long stream of random classes over only four registers produces frequent read, write and store hazards mixed with port collisions, so the cause of each stall can be told apart.

// File: rtl/lsic_pkg.sv
package lsic_pkg;

  typedef enum logic [1:0] {
    OP_ALU   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_RSVD  = 2'b11
  } op_kind_e;

  // Instruction needs the external data port.
  function automatic logic op_is_mem(op_kind_e k);
    return (k == OP_LOAD) || (k == OP_STORE);
  endfunction

  // Second source operand is architecturally read.
  function automatic logic op_reads_b(op_kind_e k);
    return k != OP_LOAD;
  endfunction

  // Destination register is written by this instruction.
  function automatic logic op_writes_dst(op_kind_e k);
    return k != OP_STORE;
  endfunction

  // Port transaction produces a register writeback on completion.
  function automatic logic op_fills_reg(op_kind_e k);
    return k == OP_LOAD;
  endfunction

endpackage

// File: rtl/lsic_scoreboard.sv
module lsic_scoreboard #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_idx,
  output logic [NUM_REGS-1:0] pend_vec
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = set_en && (set_idx == REG_W'(g));
    assign hit_clr = clr_en && (clr_idx == REG_W'(g));

    always_ff @(posedge clk) begin
      if (rst)          pend_vec[g] <= 1'b0;
      else if (hit_set) pend_vec[g] <= 1'b1;
      else if (hit_clr) pend_vec[g] <= 1'b0;
    end
  end

  // R2
  single_pending_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_vec) <= 1);

  // R1
  set_visible_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> pend_vec[$past(set_idx)]);

endmodule

// File: rtl/lsic_port_track.sv
module lsic_port_track #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_fill,
  input  logic [REG_W-1:0] start_tag,
  input  logic             mem_done,
  output logic             busy_q,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg
);

  logic             fill_q;
  logic [REG_W-1:0] tag_q;
  logic             finish;

  assign finish = mem_done && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fill_q <= 1'b0;
      tag_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      fill_q <= start_fill;
      tag_q  <= start_tag;
    end else if (finish) begin
      busy_q <= 1'b0;
      fill_q <= 1'b0;
    end
  end

  assign wb_valid = finish && fill_q;
  assign wb_reg   = wb_valid ? tag_q : '0;

  // R2
  start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy_q);

  // R8
  done_without_access_chk: assert property (@(posedge clk) disable iff (rst)
    mem_done |-> busy_q);

  // R2
  free_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_done && !start) |=> !busy_q);

endmodule

// File: rtl/lsic_hazard.sv
module lsic_hazard
  import lsic_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                instr_valid,
  input  op_kind_e            op,
  input  logic [REG_W-1:0]    dst,
  input  logic [REG_W-1:0]    src_a,
  input  logic [REG_W-1:0]    src_b,
  input  logic [NUM_REGS-1:0] pend_vec,
  input  logic                port_busy,
  output logic                raw_hit,
  output logic                waw_hit,
  output logic                port_conflict,
  output logic                stall,
  output logic                issue
);

  logic hit_a;
  logic hit_b;

  assign hit_a         = pend_vec[src_a];
  assign hit_b         = op_reads_b(op) && pend_vec[src_b];
  assign raw_hit       = hit_a || hit_b;
  assign waw_hit       = op_writes_dst(op) && pend_vec[dst];
  assign port_conflict = op_is_mem(op) && port_busy;

  assign stall = instr_valid && (raw_hit || waw_hit || port_conflict);
  assign issue = instr_valid && !stall;

endmodule

// File: rtl/ldst_issue_ctrl.sv
module ldst_issue_ctrl
  import lsic_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [1:0]       instr_op,
  input  logic [REG_W-1:0] instr_dst,
  input  logic [REG_W-1:0] instr_src_a,
  input  logic [REG_W-1:0] instr_src_b,
  output logic             stall,
  output logic             mem_start,
  output logic             mem_write,
  output logic [REG_W-1:0] mem_tag,
  input  logic             mem_done,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg
);

  op_kind_e            op;
  logic [NUM_REGS-1:0] pend_vec;
  logic                port_busy;
  logic                raw_hit;
  logic                waw_hit;
  logic                port_conflict;
  logic                issue;
  logic                load_issue;

  assign op = op_kind_e'(instr_op);

  lsic_hazard #(.NUM_REGS(NUM_REGS)) u_hazard (
    .instr_valid   (instr_valid),
    .op            (op),
    .dst           (instr_dst),
    .src_a         (instr_src_a),
    .src_b         (instr_src_b),
    .pend_vec      (pend_vec),
    .port_busy     (port_busy),
    .raw_hit       (raw_hit),
    .waw_hit       (waw_hit),
    .port_conflict (port_conflict),
    .stall         (stall),
    .issue         (issue)
  );

  assign mem_start  = issue && op_is_mem(op);
  assign load_issue = mem_start && op_fills_reg(op);
  assign mem_write  = mem_start && (op == OP_STORE);
  assign mem_tag    = mem_start ? instr_dst : '0;

  lsic_port_track #(.NUM_REGS(NUM_REGS)) u_port (
    .clk        (clk),
    .rst        (rst),
    .start      (mem_start),
    .start_fill (load_issue),
    .start_tag  (instr_dst),
    .mem_done   (mem_done),
    .busy_q     (port_busy),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg)
  );

  lsic_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk      (clk),
    .rst      (rst),
    .set_en   (load_issue),
    .set_idx  (instr_dst),
    .clr_en   (wb_valid),
    .clr_idx  (wb_reg),
    .pend_vec (pend_vec)
  );

  // R3
  raw_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && op == OP_ALU && pend_vec[instr_src_a]) |-> stall);

  // R7
  waw_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && op == OP_ALU && pend_vec[instr_dst]) |-> stall);

  // R9
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> (!stall && !mem_start));

  // R8
  wb_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !pend_vec[$past(wb_reg)]);

  // R5
  store_leaves_nothing_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_start && mem_write) |=> (pend_vec == '0));

endmodule

// File: tb/ldst_issue_ctrl_bench.sv
module ldst_issue_ctrl_bench;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic [1:0] instr_op = 2'b00;
  logic [3:0] instr_dst = '0, instr_src_a = '0, instr_src_b = '0;
  logic       stall, mem_start, mem_write, wb_valid;
  logic [3:0] mem_tag, wb_reg;
  logic       mem_done = 1'b0;

  always #2 clk = ~clk;

  ldst_issue_ctrl u_ldst_issue_ctrl (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_dst(instr_dst), .instr_src_a(instr_src_a), .instr_src_b(instr_src_b),
    .stall(stall), .mem_start(mem_start), .mem_write(mem_write), .mem_tag(mem_tag),
    .mem_done(mem_done), .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  bit mem_act = 0;
  int mem_done_at = 0;
  int last_done = 0;
  int m_pend = -1;
  bit m_busy = 0;
  int p_op[$], p_d[$], p_a[$], p_b[$];
  int iss_cyc[$];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int op, input int d, input int a,
                      input int b, output bit issued);
    bit raw, waw, busyc, is_mem, ex_stall, ex_start;
    string why;
    @(negedge clk);
    cyc++;
    mem_done    = mem_act && (cyc == mem_done_at);
    instr_valid = v;
    instr_op    = op[1:0];
    instr_dst   = d[3:0];
    instr_src_a = a[3:0];
    instr_src_b = b[3:0];
    #1;
    is_mem = (op == 1) || (op == 2);
    raw    = (m_pend >= 0) && ((a == m_pend) || ((op != 1) && (b == m_pend)));
    waw    = (m_pend >= 0) && (op != 2) && (d == m_pend);
    busyc  = is_mem && m_busy;
    ex_stall = v && (raw || waw || busyc);
    ex_start = v && !ex_stall && is_mem;
    if (!v) why = "R9";
    else if (busyc) why = "R2";
    else if (raw && op == 2) why = "R6";
    else if (raw) why = "R3";
    else if (waw) why = "R7";
    else if (op == 0) why = (m_pend >= 0) ? "R4" : "R5";
    else why = "R1";
    chk(why, "stall", int'(stall), int'(ex_stall));
    chk(why == "R9" ? "R9" : "R1", "mem_start", int'(mem_start), int'(ex_start));
    chk("R1", "mem_write", int'(mem_write), int'(ex_start && op == 2));
    chk("R1", "mem_tag", int'(mem_tag), ex_start ? d : 0);
    chk("R8", "wb_valid", int'(wb_valid), int'(mem_done && m_pend >= 0));
    chk("R8", "wb_reg", int'(wb_reg), (mem_done && m_pend >= 0) ? m_pend : 0);
    issued = v && !ex_stall;
    if (mem_done) begin
      mem_act = 0; last_done = cyc; m_busy = 0; m_pend = -1;
    end
    if (mem_start) begin
      mem_act = 1; mem_done_at = cyc + LAT - 1;
    end
    if (ex_start) begin
      m_busy = 1;
      if (op == 1) m_pend = d;
    end
  endtask

  task automatic drain();
    bit iss;
    while (m_busy || mem_act) step(0, 0, 0, 0, 0, iss);
  endtask

  task automatic add(input int op, input int d, input int a, input int b);
    p_op.push_back(op); p_d.push_back(d); p_a.push_back(a); p_b.push_back(b);
  endtask

  task automatic run_prog();
    bit iss;
    int idx = 0;
    iss_cyc.delete();
    while (idx < p_op.size()) begin
      step(1, p_op[idx], p_d[idx], p_a[idx], p_b[idx], iss);
      if (iss) begin iss_cyc.push_back(cyc); idx++; end
    end
    p_op.delete(); p_d.delete(); p_a.delete(); p_b.delete();
    drain();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    bit iss;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: clean state after reset, load issues at once
    step(0, 0, 0, 0, 0, iss);
    chk("R10", "stall after reset", int'(stall), 0);
    step(1, 1, 5, 9, 0, iss);
    chk("R10", "load issues after reset", int'(iss), 1);
    // R4: independent compute while load outstanding
    step(1, 0, 6, 7, 8, iss);
    chk("R4", "independent compute issues", int'(iss), 1);
    // R7: compute writing r5 while its load is pending
    step(1, 0, 5, 7, 8, iss);
    chk("R7", "waw compute stalls", int'(iss), 0);
    // R9: idle slot
    step(0, 1, 3, 3, 3, iss);
    chk("R9", "no stall when idle", int'(stall), 0);
    drain();

    // R6: store with pending data register
    add(1, 2, 10, 0); add(2, 0, 2, 11); run_prog();
    chk("R6", "store waits on load data", iss_cyc[1] - iss_cyc[0], LAT);
    // R5: computes after a store keep issuing
    add(2, 0, 4, 11); add(0, 3, 4, 4); add(0, 4, 3, 3); run_prog();
    chk("R5", "compute right after store", iss_cyc[1] - iss_cyc[0], 1);
    chk("R5", "second compute after store", iss_cyc[2] - iss_cyc[1], 1);

    // R11: dependent sequence
    add(1, 1, 10, 0); add(0, 2, 1, 1); add(0, 3, 2, 2); add(0, 4, 3, 3);
    add(2, 0, 4, 11); run_prog();
    chk("R3", "dependent compute issue", iss_cyc[1] - iss_cyc[0], LAT);
    chk("R11", "naive sequence cycles", last_done - iss_cyc[0] + 1, 13);

    // R12: reordered, two iterations alternating r1 / r8
    add(1, 1, 10, 0); add(0, 2, 8, 8); add(0, 3, 2, 2); add(0, 4, 3, 3); add(2, 0, 4, 11);
    add(1, 8, 10, 0); add(0, 2, 1, 1); add(0, 3, 2, 2); add(0, 4, 3, 3); add(2, 0, 4, 11);
    run_prog();
    chk("R4", "overlapped compute issue", iss_cyc[1] - iss_cyc[0], 1);
    chk("R2", "second load waits for store", iss_cyc[5] - iss_cyc[0], 10);
    chk("R12", "reordered two iterations", last_done - iss_cyc[0] + 1, 20);

    // Random stream over four registers
    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 5) != 0, $urandom % 3, $urandom % 4, $urandom % 4,
           $urandom % 4, iss);
    end
    drain();

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule